// File: doc/BRIEF.md
# Seek Address Validation and Illegal-Address Flag

This block judges each cylinder demand address that the host strobes in for a seek. The strobe arrives as a two-stage shift register. When the first stage (`strobe_a`) falls, the block compares the 9-bit demand address with the legal cylinder range and looks at the positioner's busy level. It then does one of two things:

- If the address is in range and the positioner is idle, it issues a one-cycle load pulse for the demand address register.
- Otherwise it sets a sticky illegal-address flag.

The legal range follows a configuration input. One setting gives a small drive with 203 cylinders, the other a large drive with 406 cylinders.

Three events clear the flag: an accepted address, the heads unloading, or the start of a restore. The interface sees the flag only when the drive is selected and ready. It is hidden while the second strobe stage (`strobe_b`) is high, so the host never reads a value that is still settling.

The whole block runs on one clock with a synchronous active-high reset.

Top module: `seek_addr_check`

## Requirements
- R1: After reset, `load_pulse` is 0, the internal flag is 0, and `illegal_status` is 0.
- R2: With `big_range`=0, a fall of `strobe_a` while `busy`=0 is judged as follows. Addresses 0 to 202 give `load_pulse`=1 on the following cycle and leave the flag clear. Addresses 203 to 511 set the flag and give no load pulse.
- R3: With `big_range`=1, addresses 0 to 405 are legal and 406 to 511 are illegal, with the same outcomes as in R2.
- R4: A fall of `strobe_a` while `busy`=1 sets the flag and gives no load pulse, whatever the address.
- R5: Without a fall of `strobe_a`, changes on `demand_addr`, `busy` or `big_range` leave the flag unchanged.
- R6: An accepted address (in range, not busy) clears a set flag.
- R7: `heads_loaded`=0 clears the flag on the next edge. While it is low, an illegal strobe does not set the flag.
- R8: A `restore_start` pulse clears the flag on the next edge. A clear takes priority over a set in the same cycle.
- R9: `illegal_status` is 0 whenever `sel_ready`=0, and follows the flag when `sel_ready`=1 and `strobe_b`=0.
- R10: `illegal_status` is 0 while `strobe_b`=1.
- R11: `load_pulse` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_a | input | 1 | First strobe stage; its fall triggers the check |
| strobe_b | input | 1 | Second strobe stage; hides the status while high |
| demand_addr | input | 9 | Cylinder demand address, unsigned |
| busy | input | 1 | Positioner busy with a seek |
| big_range | input | 1 | 0: 203-cylinder range, 1: 406-cylinder range |
| heads_loaded | input | 1 | Heads loaded; low clears the flag |
| restore_start | input | 1 | Pulse at the start of a restore; clears the flag |
| sel_ready | input | 1 | Drive selected and ready; enables the status |
| load_pulse | output | 1 | One-cycle load strobe for the demand address register |
| illegal_status | output | 1 | Gated illegal-address status for the interface |

## Verification
Every one of the 512 addresses is strobed with the positioner idle, under both range settings. This separates the two limit values at their exact boundaries (202/203 and 405/406) and shows that an accept clears a flag left by the previous illegal address. A second sweep strobes every fifth address while busy, which shows that busy overrides an in-range address. Directed patterns then change the address and busy level with no strobe edge present. They also pulse each clear source against a set flag, including a clear that lands on an illegal strobe, and toggle the ready and second-stage gates. Together these separate the sticky flag from the gated status.

// File: rtl/seek_chk_pkg.sv
package seek_chk_pkg;
    typedef struct packed {
        logic flag;
        logic load;
    } chk_state_t;

    typedef struct packed {
        logic prev;
    } edge_state_t;
endpackage

// File: rtl/seek_strobe_fall.sv
module seek_strobe_fall
    import seek_chk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fall
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fall = st_q.prev && !strobe;
endmodule

// File: rtl/seek_range_decode.sv
module seek_range_decode #(
    parameter int ADDR_W      = 9,
    parameter int LIMIT_SMALL = 202,
    parameter int LIMIT_LARGE = 405
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              big_range,
    output logic              in_range
);
    localparam logic [ADDR_W-1:0] LIM_S = ADDR_W'(LIMIT_SMALL);
    localparam logic [ADDR_W-1:0] LIM_L = ADDR_W'(LIMIT_LARGE);

    logic [ADDR_W-1:0] limit;

    always_comb begin
        limit    = big_range ? LIM_L : LIM_S;
        in_range = (addr <= limit);
    end
endmodule

// File: rtl/seek_addr_check.sv
module seek_addr_check
    import seek_chk_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int LIMIT_SMALL = 202,
    parameter int LIMIT_LARGE = 405
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic [ADDR_W-1:0] demand_addr,
    input  logic              busy,
    input  logic              big_range,
    input  logic              heads_loaded,
    input  logic              restore_start,
    input  logic              sel_ready,
    output logic              load_pulse,
    output logic              illegal_status
);
    chk_state_t st_d, st_q;
    logic a_fall;
    logic in_range;
    logic accept;
    logic reject;
    logic clear_req;
    logic flag_q;

    seek_strobe_fall u_fall (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe_a),
        .fall   (a_fall)
    );

    seek_range_decode #(
        .ADDR_W      (ADDR_W),
        .LIMIT_SMALL (LIMIT_SMALL),
        .LIMIT_LARGE (LIMIT_LARGE)
    ) u_range (
        .addr      (demand_addr),
        .big_range (big_range),
        .in_range  (in_range)
    );

    always_comb begin
        st_d      = st_q;
        accept    = a_fall && in_range && !busy;
        reject    = a_fall && (!in_range || busy);
        clear_req = !heads_loaded || restore_start || accept;
        st_d.load = accept;
        if (clear_req)   st_d.flag = 1'b0;
        else if (reject) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag_q         = st_q.flag;
    assign load_pulse     = st_q.load;
    assign illegal_status = st_q.flag && sel_ready && !strobe_b;
endmodule

// File: rtl/seek_addr_check_sva.sv
module seek_addr_check_sva (
    input logic clk,
    input logic rst,
    input logic strobe_a,
    input logic strobe_b,
    input logic busy,
    input logic heads_loaded,
    input logic restore_start,
    input logic sel_ready,
    input logic load_pulse,
    input logic illegal_status,
    input logic flag_q
);
    // R11
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !load_pulse);

    // R9
    p_ready_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !sel_ready |-> !illegal_status);

    // R10
    p_stage_b_mask_r10: assert property (@(posedge clk) disable iff (rst)
        strobe_b |-> !illegal_status);

    // R4
    p_busy_rejects_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe_a) && busy && heads_loaded && !restore_start)
        |=> (!load_pulse && flag_q));

    // R7
    p_unload_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !heads_loaded |=> !flag_q);

    // R8
    p_restore_clears_r8: assert property (@(posedge clk) disable iff (rst)
        restore_start |=> !flag_q);

    // R5
    p_hold_no_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (!$fell(strobe_a) && heads_loaded && !restore_start) |=> $stable(flag_q));

    // R11: a pulse only follows a strobe fall
    p_pulse_needs_edge_r11: assert property (@(posedge clk) disable iff (rst)
        !$fell(strobe_a) |=> !load_pulse);
endmodule

bind seek_addr_check seek_addr_check_sva u_sva (
    .clk            (clk),
    .rst            (rst),
    .strobe_a       (strobe_a),
    .strobe_b       (strobe_b),
    .busy           (busy),
    .heads_loaded   (heads_loaded),
    .restore_start  (restore_start),
    .sel_ready      (sel_ready),
    .load_pulse     (load_pulse),
    .illegal_status (illegal_status),
    .flag_q         (flag_q)
);

// File: tb/tb_seek_addr_check.sv
module tb_seek_addr_check;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_a = 1'b0;
    logic       strobe_b = 1'b0;
    logic [8:0] demand_addr = '0;
    logic       busy = 1'b0;
    logic       big_range = 1'b0;
    logic       heads_loaded = 1'b1;
    logic       restore_start = 1'b0;
    logic       sel_ready = 1'b1;
    logic       load_pulse;
    logic       illegal_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    seek_addr_check dut (
        .clk            (clk),
        .rst            (rst),
        .strobe_a       (strobe_a),
        .strobe_b       (strobe_b),
        .demand_addr    (demand_addr),
        .busy           (busy),
        .big_range      (big_range),
        .heads_loaded   (heads_loaded),
        .restore_start  (restore_start),
        .sel_ready      (sel_ready),
        .load_pulse     (load_pulse),
        .illegal_status (illegal_status)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0b exp=%0b", req, act, exp);
        end
    endtask

    // Entered at a falling clock edge; returns at the falling edge after the
    // rising edge that sees strobe_a low.
    task automatic do_strobe(input logic [8:0] a, input logic b);
        demand_addr = a;
        busy        = b;
        strobe_a    = 1'b1;
        @(negedge clk);
        strobe_a    = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 load", load_pulse, 1'b0);
        chk("R1 status", illegal_status, 1'b0);

        // Full sweeps, positioner idle
        for (int cfg = 0; cfg < 2; cfg++) begin
            big_range = cfg[0];
            for (int a = 0; a < 512; a++) begin
                int  lim;
                logic ok;
                lim = (cfg == 1) ? 405 : 202;
                ok  = (a <= lim);
                do_strobe(a[8:0], 1'b0);
                chk(cfg == 1 ? "R3 load" : "R2 load", load_pulse, ok);
                chk(cfg == 1 ? "R3 flag" : "R2 flag", illegal_status, !ok);
                @(negedge clk);
                chk("R11", load_pulse, 1'b0);
            end
        end

        // Busy sweep
        for (int cfg = 0; cfg < 2; cfg++) begin
            big_range = cfg[0];
            for (int a = 0; a < 512; a += 5) begin
                do_strobe(a[8:0], 1'b1);
                chk("R4 load", load_pulse, 1'b0);
                chk("R4 flag", illegal_status, 1'b1);
                do_strobe(9'd10, 1'b0);
                chk("R6 clear", illegal_status, 1'b0);
            end
        end

        // R5: no edge, flag stays set
        big_range = 1'b0;
        do_strobe(9'd300, 1'b0);
        chk("R5 setup", illegal_status, 1'b1);
        demand_addr = 9'd5; busy = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 hold set", illegal_status, 1'b1);
        chk("R5 no load", load_pulse, 1'b0);
        do_strobe(9'd5, 1'b0);
        demand_addr = 9'd500; busy = 1'b1; big_range = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 hold clear", illegal_status, 1'b0);
        big_range = 1'b0; busy = 1'b0;

        // R9 / R10 gating
        do_strobe(9'd203, 1'b0);
        sel_ready = 1'b0;
        #1;
        chk("R9 gated", illegal_status, 1'b0);
        sel_ready = 1'b1;
        #1;
        chk("R9 pass", illegal_status, 1'b1);
        strobe_b = 1'b1;
        #1;
        chk("R10 masked", illegal_status, 1'b0);
        strobe_b = 1'b0;
        #1;
        chk("R10 unmasked", illegal_status, 1'b1);
        @(negedge clk);

        // R7: unload clears, and blocks a same-cycle set
        heads_loaded = 1'b0;
        @(negedge clk);
        chk("R7 clear", illegal_status, 1'b0);
        do_strobe(9'd450, 1'b0);
        chk("R7 blocks set", illegal_status, 1'b0);
        heads_loaded = 1'b1;
        @(negedge clk);

        // R8: restore clears, and wins over a same-cycle set
        do_strobe(9'd450, 1'b0);
        chk("R8 setup", illegal_status, 1'b1);
        restore_start = 1'b1;
        @(negedge clk);
        restore_start = 1'b0;
        chk("R8 clear", illegal_status, 1'b0);
        demand_addr = 9'd450;
        strobe_a = 1'b1;
        @(negedge clk);
        strobe_a = 1'b0;
        restore_start = 1'b1;
        @(negedge clk);
        restore_start = 1'b0;
        chk("R8 priority", illegal_status, 1'b0);

        // R1 again: reset clears a set flag
        do_strobe(9'd511, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset flag", illegal_status, 1'b0);
        chk("R1 reset load", load_pulse, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule